// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block produces the word address stream for synchronous burst reads from a memory array that is 16 bits wide. A host opens a burst by pulling the active-low address strobe low while chip enable is high. On that clock edge the block captures the start word address and a 16-bit configuration word. It then waits a programmable number of clocks before the first word. After that it presents one word address per clock with `data_valid` high. A `wait_o` indication marks the clocks in which no valid word is present.

The configuration word selects the transfer. Bit 15 chooses the mode: 0 is synchronous burst and 1 is asynchronous page. Bits [14:11] give the first-access latency count. Bit 8 sets the timing of `wait_o`. Bit 3 chooses wrapped or linear ordering. Bits [2:0] give the burst length. Wrapped bursts cycle inside an aligned group of 4, 8 or 16 words. Linear bursts count upward across group boundaries. A continuous burst is always linear and runs until chip enable falls. When a linear burst steps from the last word of a 16-word line into the next line, the block inserts stall clocks. The number of stall clocks is derived from the latency count.

The controller has four states. IDLE waits for a strobe. LATENCY counts the first-access delay. DATA issues one word per clock. STALL holds the line-crossing delay.

The transitions are:
- A strobe in any state moves to LATENCY.
- LATENCY moves to DATA when its count expires.
- DATA moves to STALL on a line crossing that has a non-zero stall length.
- DATA moves to IDLE after the last word of a fixed-length burst.
- STALL moves back to DATA when its count expires.
- Chip enable low moves any state to IDLE.

Top module: `burst_addr_seq`

## Requirements
- R1: When configuration bit 15 is 1 (asynchronous page mode), a strobe is ignored. `data_valid` and `wait_o` stay 0 and no burst starts.
- R2: A strobe is `addr_vld_n` = 0 with `chip_en` = 1 and bit 15 = 0, sampled at a rising edge. It captures `start_addr` and the configuration word, and the first word address presented equals `start_addr`.
- R3: Let L be configuration bits [14:11], with a code of 0 treated as 1. `data_valid` first goes high in the cycle that follows the L-th rising edge after the strobe edge.
- R4: Bits [2:0] set the burst length: 3'b001 gives 4 words, 3'b010 gives 8 words and 3'b011 gives 16 words. Every other code gives a continuous burst. In the cycle after the last word of a fixed-length burst, `data_valid` and `wait_o` are 0.
- R5: With bit 3 = 0 and a fixed length, addresses wrap inside the aligned group of the burst length. A 4-word burst from offset 2 gives offsets 2-3-0-1, and from offset 1 it gives 1-2-3-0.
- R6: With bit 3 = 1, or in any continuous burst whatever bit 3 holds, each word address is the previous one plus one, across all group boundaries.
- R7: In a linear burst, stepping from a word at line offset 15 (address bits [3:0] = 4'hF) to the next word inserts S = max(L - 2, 0) cycles. During these cycles `data_valid` is 0. The stall happens only when a further word remains.
- R8: With bit 8 = 0, `wait_o` is 1 exactly in the cycles of an active burst with no valid word, which are the latency and stall cycles. With bit 8 = 1, `wait_o` is 1 in the cycle before each such cycle instead.
- R9: When `chip_en` is sampled low at a rising edge, the burst ends. In the following cycle `data_valid` and `wait_o` are 0.
- R10: While `data_valid` is 1, `word_addr` advances to the next address of the burst order on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip enable, high to allow bursts |
| addr_vld_n | input | 1 | Active-low address strobe |
| start_addr | input | AW | Start word address captured on the strobe |
| cfg_word | input | 16 | Read configuration word captured on the strobe |
| word_addr | output | AW | Current word address of the burst |
| data_valid | output | 1 | High when `word_addr` names a valid word |
| wait_o | output | 1 | High when the data of the burst is not valid (or, in early mode, about to become invalid) |

## Verification
The embedded assertions check several properties on every cycle. A clock with chip enable low is followed by no valid word. An ignored strobe in asynchronous mode leaves the block idle. Consecutive valid words step by one in linear order and stay inside one 16-word line in wrapped order. A stall cycle always sits at the start of a new line. Only the bench scenarios can show the exact clock of the first word for each latency code, the full wrap order for each group size, and the number of stall cycles at a crossing. The same is true for the position of `wait_o` in both timing modes and the clean end of fixed-length bursts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int CFG_W        = 16;
    localparam int LAT_W        = 4;
    localparam int MAX_GRP_LOG2 = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATENCY,
        ST_DATA,
        ST_STALL
    } seq_state_t;

    typedef struct packed {
        logic             sync;      // synchronous burst mode selected
        logic             cont;      // continuous burst
        logic             linear;    // linear ordering (forced for continuous)
        logic             early;     // wait indication one cycle ahead
        logic [2:0]       grp_log2;  // log2 of group length
        logic [LAT_W-1:0] lat;       // effective first-access latency (>= 1)
    } burst_cfg_t;

    function automatic logic is_gap(seq_state_t s);
        return (s == ST_LATENCY) || (s == ST_STALL);
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_seq_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output burst_cfg_t       dec
);
    logic [LAT_W-1:0] lat_raw;

    always_comb begin
        lat_raw      = cfg_word[14:11];
        dec.sync     = ~cfg_word[15];
        dec.early    = cfg_word[8];
        dec.lat      = (lat_raw == '0) ? LAT_W'(1) : lat_raw;
        unique case (cfg_word[2:0])
            3'b001:  begin dec.grp_log2 = 3'd2; dec.cont = 1'b0; end
            3'b010:  begin dec.grp_log2 = 3'd3; dec.cont = 1'b0; end
            3'b011:  begin dec.grp_log2 = 3'd4; dec.cont = 1'b0; end
            default: begin dec.grp_log2 = 3'(MAX_GRP_LOG2); dec.cont = 1'b1; end
        endcase
        dec.linear = dec.cont | cfg_word[3];
    end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
    parameter int AW        = 16,
    parameter int LINE_LOG2 = 4
) (
    input  logic [AW-1:0] cur_addr,
    input  logic          linear,
    input  logic [2:0]    grp_log2,
    output logic [AW-1:0] nxt_addr,
    output logic          line_end
);
    logic [AW-1:0] grp_mask;
    logic [AW-1:0] plus_one;

    always_comb begin
        grp_mask = (AW'(1) << grp_log2) - AW'(1);
        plus_one = cur_addr + AW'(1);
        nxt_addr = linear ? plus_one
                          : ((cur_addr & ~grp_mask) | (plus_one & grp_mask));
        line_end = &cur_addr[LINE_LOG2-1:0];
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LINE_LOG2 = 4,
    parameter int EOWL_FREE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             addr_vld_n,
    input  logic [AW-1:0]    start_addr,
    input  logic [CFG_W-1:0] cfg_word,
    output logic [AW-1:0]    word_addr,
    output logic             data_valid,
    output logic             wait_o
);
    localparam int LEFT_W = MAX_GRP_LOG2 + 1;

    seq_state_t       state_q, state_d;
    burst_cfg_t       cfg_q, cfg_d, dec_in;
    logic [AW-1:0]    addr_q, addr_d, nxt_addr;
    logic [LAT_W-1:0] cnt_q, cnt_d, stall_len;
    logic [LEFT_W-1:0] left_q, left_d;
    logic             line_end, strobe_fire, last_word, crossing, early_sel;

    burst_cfg_decode i_decode (
        .cfg_word (cfg_word),
        .dec      (dec_in)
    );

    burst_addr_step #(.AW(AW), .LINE_LOG2(LINE_LOG2)) i_step (
        .cur_addr (addr_q),
        .linear   (cfg_q.linear),
        .grp_log2 (cfg_q.grp_log2),
        .nxt_addr (nxt_addr),
        .line_end (line_end)
    );

    assign strobe_fire = chip_en & ~addr_vld_n & dec_in.sync;
    assign stall_len   = (cfg_q.lat > LAT_W'(EOWL_FREE)) ? cfg_q.lat - LAT_W'(EOWL_FREE) : '0;
    assign last_word   = ~cfg_q.cont && (left_q == '0);
    assign crossing    = cfg_q.linear && line_end && ~last_word;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        addr_d  = addr_q;
        cnt_d   = cnt_q;
        left_d  = left_q;
        if (!chip_en) begin
            state_d = ST_IDLE;
        end else if (strobe_fire) begin
            state_d = ST_LATENCY;
            cfg_d   = dec_in;
            addr_d  = start_addr;
            cnt_d   = dec_in.lat - LAT_W'(1);
            left_d  = (LEFT_W'(1) << dec_in.grp_log2) - LEFT_W'(1);
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_LATENCY: begin
                    if (cnt_q == '0) state_d = ST_DATA;
                    else             cnt_d   = cnt_q - LAT_W'(1);
                end
                ST_DATA: begin
                    if (last_word) begin
                        state_d = ST_IDLE;
                    end else begin
                        addr_d = nxt_addr;
                        if (!cfg_q.cont) left_d = left_q - LEFT_W'(1);
                        if (crossing && stall_len != '0) begin
                            state_d = ST_STALL;
                            cnt_d   = stall_len - LAT_W'(1);
                        end
                    end
                end
                ST_STALL: begin
                    if (cnt_q == '0) state_d = ST_DATA;
                    else             cnt_d   = cnt_q - LAT_W'(1);
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
            addr_q  <= addr_d;
            cnt_q   <= cnt_d;
            left_q  <= left_d;
        end
    end

    // outputs
    always_comb begin
        early_sel  = strobe_fire ? dec_in.early : cfg_q.early;
        data_valid = (state_q == ST_DATA);
        word_addr  = addr_q;
        wait_o     = early_sel ? is_gap(state_d) : is_gap(state_q);
    end

    AST_CE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> !data_valid); // R9

    AST_ASYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !addr_vld_n && cfg_word[15] && state_q == ST_IDLE) |=> !data_valid); // R1

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && cfg_q.linear) |=> (!data_valid || word_addr == $past(word_addr) + AW'(1))); // R6

    AST_WRAP_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !cfg_q.linear) |=>
            (!data_valid || word_addr[AW-1:LINE_LOG2] == $past(word_addr[AW-1:LINE_LOG2]))); // R5

    AST_STALL_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> (word_addr[LINE_LOG2-1:0] == '0)); // R7

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int EOWL_FREE  = 2;

    logic          clk = 1'b0;
    logic          rst_n, chip_en, addr_vld_n;
    logic [AW-1:0] start_addr;
    logic [15:0]   cfg_word;
    logic [AW-1:0] word_addr;
    logic          data_valid, wait_o;

    typedef struct {
        bit            dv;
        bit            wt;
        logic [AW-1:0] a;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.AW(AW), .LINE_LOG2(4), .EOWL_FREE(EOWL_FREE)) i_burst_addr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .addr_vld_n (addr_vld_n),
        .start_addr (start_addr),
        .cfg_word   (cfg_word),
        .word_addr  (word_addr),
        .data_valid (data_valid),
        .wait_o     (wait_o)
    );

    // mode(15) latency(14:11) early-wait(8) linear(3) length(2:0)
    function automatic logic [15:0] mk_cfg(bit async_m, int lat, bit early, bit linear, logic [2:0] bl);
        return {async_m, 4'(lat), 2'b00, early, 4'b0000, linear, bl};
    endfunction

    // monitor: pops one expected cycle per falling edge
    always @(negedge clk) begin
        exp_t e;
        if (!finished && q.size() > 0) begin
            e = q.pop_front();
            n_checks++;
            if (data_valid !== e.dv || wait_o !== e.wt || (e.dv && word_addr !== e.a)) begin
                n_fail++;
                $display("FAIL %s: dv=%0b wait=%0b addr=%h, expected dv=%0b wait=%0b addr=%h",
                         e.tag, data_valid, wait_o, word_addr, e.dv, e.wt, e.a);
            end
        end
    end

    // driver: builds the expected cycle stream from the requirements, then drives the strobe
    task automatic run_burst(logic [15:0] cfg, logic [AW-1:0] start, int ncont, int cut, string tag);
        bit            dvs[$];
        bit            act[$];
        logic [AW-1:0] ads[$];
        int            lat    = (cfg[14:11] == 4'd0) ? 1 : int'(cfg[14:11]);
        bit            cont   = !(cfg[2:0] inside {3'd1, 3'd2, 3'd3});
        int            k      = cont ? 4 : int'(cfg[2:0]) + 1;
        int            n      = cont ? ncont : (1 << k);
        bit            linear = cont || cfg[3];
        int            stall  = (lat > EOWL_FREE) ? lat - EOWL_FREE : 0;
        logic [AW-1:0] a      = start;
        logic [AW-1:0] mask   = AW'((1 << k) - 1);
        bit            drop   = cont || (cut > 0);
        exp_t          e;
        if (cfg[15]) begin
            for (int i = 0; i < lat + 2; i++) begin dvs.push_back(0); act.push_back(0); ads.push_back('0); end
            drop = 1'b0;
        end else begin
            for (int i = 0; i < lat; i++) begin dvs.push_back(0); act.push_back(1); ads.push_back('0); end
            for (int w = 0; w < n; w++) begin
                dvs.push_back(1); act.push_back(1); ads.push_back(a);
                if (w < n - 1) begin
                    if (linear) begin
                        if (a[3:0] == 4'hF)
                            for (int s = 0; s < stall; s++) begin dvs.push_back(0); act.push_back(1); ads.push_back('0); end
                        a = a + AW'(1);
                    end else begin
                        a = (a & ~mask) | ((a + AW'(1)) & mask);
                    end
                end
            end
        end
        if (cut > 0) while (dvs.size() > cut) begin void'(dvs.pop_back()); void'(act.pop_back()); void'(ads.pop_back()); end
        dvs.push_back(0); act.push_back(0); ads.push_back('0);

        @(negedge clk);
        cfg_word   = cfg;
        start_addr = start;
        addr_vld_n = 1'b0;
        #1;
        for (int i = 0; i < dvs.size(); i++) begin
            bit gap_now = act[i] && !dvs[i];
            bit gap_nxt = (i + 1 < dvs.size()) ? (act[i+1] && !dvs[i+1]) : 1'b0;
            e.dv  = dvs[i];
            e.a   = ads[i];
            e.wt  = cfg[8] ? gap_nxt : gap_now;
            e.tag = tag;
            q.push_back(e);
        end
        @(posedge clk);
        #1 addr_vld_n = 1'b1;
        if (drop) begin
            while (q.size() > 1) begin @(negedge clk); #1; end
            chip_en = 1'b0;
            while (q.size() > 0) begin @(negedge clk); #1; end
            chip_en = 1'b1;
        end else begin
            while (q.size() > 0) begin @(negedge clk); #1; end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired: run hung");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        chip_en    = 1'b1;
        addr_vld_n = 1'b1;
        start_addr = '0;
        cfg_word   = '0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (data_valid !== 1'b0 || wait_o !== 1'b0) begin
            n_fail++;
            $display("FAIL reset R9: dv=%0b wait=%0b, expected dv=0 wait=0", data_valid, wait_o);
        end
        rst_n = 1'b1;

        // R2 R3 R4 R5 R8 R10: 4-word wrap from offset 2 -> 2-3-0-1
        run_burst(mk_cfg(0, 3, 0, 0, 3'b001), 16'h0102, 0, 0, "R2/R3/R5/R10 wrap4 off2");
        // R5: 4-word wrap from offset 1 -> 1-2-3-0
        run_burst(mk_cfg(0, 3, 0, 0, 3'b001), 16'h0101, 0, 0, "R5 wrap4 off1");
        // R5 R8: 8-word wrap, early wait
        run_burst(mk_cfg(0, 5, 1, 0, 3'b010), 16'h0025, 0, 0, "R5/R8 wrap8 early");
        // R4 R5 R7: 16-word wrap never stalls
        run_burst(mk_cfg(0, 6, 0, 0, 3'b011), 16'h003A, 0, 0, "R4/R5/R7 wrap16");
        // R6 R7: 4-word linear crossing a line, stall of 3
        run_burst(mk_cfg(0, 5, 0, 1, 3'b001), 16'h000E, 0, 0, "R6/R7 lin4 cross");
        // R6 R7: 8-word linear, stall of 1
        run_burst(mk_cfg(0, 3, 0, 1, 3'b010), 16'h0A0C, 0, 0, "R6/R7 lin8 cross");
        // R7 R8: 16-word linear with early wait, stall of 2
        run_burst(mk_cfg(0, 4, 1, 1, 3'b011), 16'h0047, 0, 0, "R7/R8 lin16 early");
        // R4 R6 R7 R9: continuous ignores wrap bit, two crossings, ended by chip enable
        run_burst(mk_cfg(0, 6, 0, 0, 3'b111), 16'h00FC, 24, 0, "R4/R6/R7/R9 continuous");
        // R7 R8: continuous with latency 2 -> no stall at crossing, early wait
        run_burst(mk_cfg(0, 2, 1, 1, 3'b000), 16'h1F0E, 20, 0, "R7/R8 continuous lat2");
        // R3: latency code 0 acts as 1
        run_burst(mk_cfg(0, 0, 0, 1, 3'b001), 16'h0200, 0, 0, "R3 latency zero");
        // R3: maximum latency
        run_burst(mk_cfg(0, 15, 0, 1, 3'b001), 16'h0300, 0, 0, "R3 latency 15");
        // R1: asynchronous mode strobe ignored
        run_burst(mk_cfg(1, 3, 0, 1, 3'b001), 16'h0400, 0, 0, "R1 async ignored");
        // R9: chip enable cut mid burst
        run_burst(mk_cfg(0, 2, 0, 1, 3'b011), 16'h0500, 0, 5, "R9 cut by chip enable");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule